// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Controller

This block is the slave side of a two-wire serial memory. It watches the bus clock and data lines, finds start and stop conditions, and checks the device select byte. It then takes a word address and either collects write data or streams read data back. It works from a fast system clock that samples the bus lines. It pulls the data line low through an output enable and never drives it high, so several devices can share the line as a wired AND. It never generates the bus clock.

Write data is not stored in the array right away. It collects in a 16-byte page latch. A stop condition commits the latched bytes to one page of the array in a single step, and a self-timed programming window follows. The device refuses to be selected until that window ends. A write-protect input lets protected writes go through the whole bus exchange, but it stops the commit.

The array holds 1024 or 2048 bytes, chosen by parameter. The high address bits travel in the select byte.

Top module: `serial_eeprom_slave`

## Requirements
- R1: After reset the data-line output enable is low, so SDA is released.
- R2: A select byte is accepted only if its top four bits are 1010 and its bit 0 is the direction (1 = read). Bits 3..1 carry the block number: their low (log2(MEM_BYTES)-8) bits supply address bits above bit 7, and any higher bits of that field must be 0. With the default 1024 bytes, bit 3 must be 0. Any other select byte is not acknowledged, and the device ignores the bus until the next start or stop.
- R3: For an accepted select byte, a word address byte or a write data byte, the device holds SDA low during the ninth SCL clock.
- R4: Bytes written and then closed by a stop are stored at their addresses, and they read back after the programming window ends.
- R5: During a write, the low four address bits advance after each data byte and wrap within the 16-byte page. A 17th data byte replaces the first one.
- R6: For PROG_CYCLES system clocks after a committing stop, a matching select byte is not acknowledged.
- R7: While the write-protect input is high, data bytes are still acknowledged. The stop then leaves the array unchanged and starts no programming window.
- R8: A read returns the byte at the current address and then advances the address. The address runs across the whole array and wraps from the last byte to 0. A master no-acknowledge ends the read.
- R9: The device changes its SDA drive only while SCL is low. It turns the drive on only after a falling SCL edge.
- R10: A write select and a word address, followed by a repeated start and a read select, read from that address, and nothing is committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the wire |
| wp_i | input | 1 | High blocks every change to the array |
| sda_oe_o | output | 1 | High pulls SDA low; low releases it |

## Verification
Most internal faults show up at the ports within one byte time. A wrong bit counter or a wrong state shifts the acknowledge slot, so the master reads a no-acknowledge or gets a data byte shifted by one bit at the next ninth clock. A broken page-latch index or a broken commit path stays hidden until a later read returns the wrong byte. A wrong busy timer shows up as an acknowledge, or a missing one, on the first select byte after a stop. The bench therefore reads back every written location, and it probes the select byte both inside and after the programming window.

// File: rtl/eep_pkg.sv
package eep_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEL,
        ST_ADDR,
        ST_WR,
        ST_RD,
        ST_WAIT
    } eep_st_e;

    localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/eep_bus_cond.sv
module eep_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    assign scl_rise_o = scl_i & ~scl_q;
    assign scl_fall_o = ~scl_i & scl_q;
    assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
    assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/eep_prog_timer.sv
module eep_prog_timer #(
    parameter int CYCLES = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i)
            cnt_d = CW'(CYCLES);
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/eep_page_latch.sv
module eep_page_latch #(
    parameter int PAGE_BYTES = 16,
    parameter int PW         = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr_i,
    input  logic                       we_i,
    input  logic [PW-1:0]              idx_i,
    input  logic [7:0]                 din_i,
    output logic [PAGE_BYTES-1:0][7:0] data_o,
    output logic [PAGE_BYTES-1:0]      mask_o
);
    logic [PAGE_BYTES-1:0][7:0] data_d, data_q;
    logic [PAGE_BYTES-1:0]      mask_d, mask_q;

    always_comb begin
        data_d = data_q;
        mask_d = mask_q;
        if (clr_i) begin
            mask_d = '0;
        end else if (we_i) begin
            data_d[idx_i] = din_i;
            mask_d[idx_i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            mask_q <= '0;
        end else begin
            data_q <= data_d;
            mask_q <= mask_d;
        end
    end

    assign data_o = data_q;
    assign mask_o = mask_q;
endmodule

// File: rtl/eep_array.sv
module eep_array #(
    parameter int MEM_BYTES  = 1024,
    parameter int PAGE_BYTES = 16
) (
    input  logic                       clk,
    input  logic                       commit_i,
    input  logic [$clog2(MEM_BYTES)-$clog2(PAGE_BYTES)-1:0] page_i,
    input  logic [PAGE_BYTES-1:0][7:0] data_i,
    input  logic [PAGE_BYTES-1:0]      mask_i,
    input  logic [$clog2(MEM_BYTES)-1:0] rd_addr_i,
    output logic [7:0]                 rd_data_o
);
    localparam int PW = $clog2(PAGE_BYTES);

    logic [7:0] mem_q [MEM_BYTES];

    always_ff @(posedge clk) begin
        if (commit_i) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (mask_i[i])
                    mem_q[{page_i, PW'(i)}] <= data_i[i];
            end
        end
    end

    assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave
    import eep_pkg::*;
#(
    parameter int MEM_BYTES   = 1024,
    parameter int PAGE_BYTES  = 16,
    parameter int PROG_CYCLES = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic wp_i,
    output logic sda_oe_o
);
    localparam int AW       = $clog2(MEM_BYTES);
    localparam int PW       = $clog2(PAGE_BYTES);
    localparam int BLK_BITS = AW - 8;
    localparam logic [2:0] BLK_MASK = 3'((1 << BLK_BITS) - 1);

    typedef struct packed {
        eep_st_e     st;
        logic [3:0]  cnt;
        logic        ack;
        logic        oe;
        logic [7:0]  sh;
        logic [7:0]  tx;
        logic [AW-1:0] addr;
        logic        dirty;
    } ctl_t;

    ctl_t r_q, r_d;

    logic scl_rise, scl_fall, bus_start, bus_stop;
    logic busy, commit, lat_we, lat_clr, sel_ok;
    logic [7:0] rd_data;
    logic [PAGE_BYTES-1:0][7:0] lat_data;
    logic [PAGE_BYTES-1:0]      lat_mask;

    eep_bus_cond u_cond (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
        .start_o(bus_start), .stop_o(bus_stop)
    );

    eep_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start_i(commit), .busy_o(busy)
    );

    eep_page_latch #(.PAGE_BYTES(PAGE_BYTES), .PW(PW)) u_latch (
        .clk(clk), .rst_n(rst_n), .clr_i(lat_clr), .we_i(lat_we),
        .idx_i(r_q.addr[PW-1:0]), .din_i(r_q.sh),
        .data_o(lat_data), .mask_o(lat_mask)
    );

    eep_array #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_array (
        .clk(clk), .commit_i(commit), .page_i(r_q.addr[AW-1:PW]),
        .data_i(lat_data), .mask_i(lat_mask),
        .rd_addr_i(r_q.addr), .rd_data_o(rd_data)
    );

    assign sel_ok = (r_q.sh[7:4] == DEV_CODE) && ((r_q.sh[3:1] & ~BLK_MASK) == 3'b000);

    always_comb begin
        r_d     = r_q;
        lat_we  = 1'b0;
        lat_clr = 1'b0;
        commit  = 1'b0;
        if (bus_start) begin
            r_d.st    = ST_SEL;
            r_d.cnt   = '0;
            r_d.ack   = 1'b0;
            r_d.oe    = 1'b0;
            r_d.dirty = 1'b0;
        end else if (bus_stop) begin
            commit    = r_q.dirty & ~wp_i;
            r_d.st    = ST_IDLE;
            r_d.cnt   = '0;
            r_d.ack   = 1'b0;
            r_d.oe    = 1'b0;
            r_d.dirty = 1'b0;
        end else if (scl_rise) begin
            if ((r_q.st inside {ST_SEL, ST_ADDR, ST_WR}) && !r_q.ack && r_q.cnt < 4'd8) begin
                r_d.sh  = {r_q.sh[6:0], sda_i};
                r_d.cnt = r_q.cnt + 4'd1;
            end else if (r_q.st == ST_RD && r_q.cnt == 4'd9) begin
                r_d.addr = r_q.addr + 1'b1;
                r_d.cnt  = '0;
                if (sda_i) r_d.st = ST_WAIT;
            end
        end else if (scl_fall) begin
            if (r_q.ack) begin
                r_d.ack = 1'b0;
                r_d.oe  = 1'b0;
                r_d.cnt = '0;
                if (r_q.st == ST_RD) begin
                    r_d.tx  = {rd_data[6:0], 1'b0};
                    r_d.oe  = ~rd_data[7];
                    r_d.cnt = 4'd1;
                end
            end else if (r_q.st == ST_RD) begin
                if (r_q.cnt == 4'd0) begin
                    r_d.tx  = {rd_data[6:0], 1'b0};
                    r_d.oe  = ~rd_data[7];
                    r_d.cnt = 4'd1;
                end else if (r_q.cnt < 4'd8) begin
                    r_d.tx  = {r_q.tx[6:0], 1'b0};
                    r_d.oe  = ~r_q.tx[7];
                    r_d.cnt = r_q.cnt + 4'd1;
                end else if (r_q.cnt == 4'd8) begin
                    r_d.oe  = 1'b0;
                    r_d.cnt = 4'd9;
                end
            end else if ((r_q.st inside {ST_SEL, ST_ADDR, ST_WR}) && r_q.cnt == 4'd8) begin
                r_d.ack = 1'b1;
                r_d.oe  = 1'b1;
                case (r_q.st)
                    ST_SEL: begin
                        if (sel_ok && !busy) begin
                            r_d.st          = r_q.sh[0] ? ST_RD : ST_ADDR;
                            r_d.addr[AW-1:8] = r_q.sh[BLK_BITS:1];
                        end else begin
                            r_d.st  = ST_WAIT;
                            r_d.ack = 1'b0;
                            r_d.oe  = 1'b0;
                        end
                    end
                    ST_ADDR: begin
                        r_d.addr[7:0] = r_q.sh;
                        lat_clr       = 1'b1;
                        r_d.st        = ST_WR;
                    end
                    default: begin
                        lat_we             = 1'b1;
                        r_d.addr[PW-1:0]   = r_q.addr[PW-1:0] + 1'b1;
                        r_d.dirty          = 1'b1;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, cnt: '0, ack: 1'b0, oe: 1'b0, sh: '0,
                     tx: '0, addr: '0, dirty: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_oe_o = r_q.oe;
endmodule

// File: rtl/eep_chk.sv
module eep_chk #(
    parameter int PROG_CYCLES = 500
) (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic wp_i,
    input logic sda_oe_o,
    input logic busy,
    input logic bus_stop
);
    int unsigned bcnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    bcnt_q <= 0;
        else if (busy) bcnt_q <= bcnt_q + 1;
        else           bcnt_q <= 0;
    end

    // R9
    oe_rise_on_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_i);

    // R6
    no_ack_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !$rose(sda_oe_o));

    // R7
    busy_needs_unprotected_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(bus_stop) && !$past(wp_i)));

    // R6
    busy_window_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (bcnt_q < PROG_CYCLES));

    // R6
    busy_window_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (bcnt_q == PROG_CYCLES));
endmodule

bind serial_eeprom_slave eep_chk #(.PROG_CYCLES(PROG_CYCLES)) chk_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .wp_i(wp_i),
    .sda_oe_o(sda_oe_o), .busy(busy), .bus_stop(bus_stop)
);

// File: tb/serial_eeprom_slave_tb.sv
module serial_eeprom_slave_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 8;
    localparam int PROG       = 500;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic wp = 1'b0;
    logic sda_oe;
    logic sda_bus;

    assign sda_bus = sda_m & ~sda_oe;

    always #(CLK_PERIOD / 2) clk = ~clk;

    serial_eeprom_slave #(.MEM_BYTES(1024), .PAGE_BYTES(16), .PROG_CYCLES(PROG)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
        .wp_i(wp), .sda_oe_o(sda_oe)
    );

    typedef struct {
        string      tag;
        logic [7:0] val;
    } item_t;

    item_t exp_q[$];
    item_t act_q[$];
    item_t mon_e, mon_a;
    int checks = 0;
    int fails = 0;
    bit done = 0;

    // scoreboard monitor
    always @(negedge clk) begin
        if (exp_q.size() > 0 && act_q.size() > 0) begin
            mon_e = exp_q.pop_front();
            mon_a = act_q.pop_front();
            checks++;
            if (mon_a.val !== mon_e.val) begin
                fails++;
                $display("FAIL %s actual=%h expected=%h", mon_e.tag, mon_a.val, mon_e.val);
            end
        end
    end

    task automatic expect_item(input string tag, input logic [7:0] v);
        exp_q.push_back('{tag, v});
    endtask

    task automatic put_act(input logic [7:0] v);
        act_q.push_back('{"", v});
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q);
        scl = 1'b1;   wq(Q);
        sda_m = 1'b0; wq(Q);
        scl = 1'b0;   wq(Q);
    endtask

    task automatic bus_stop();
        scl = 1'b0;   sda_m = 1'b0; wq(Q);
        scl = 1'b1;   wq(Q);
        sda_m = 1'b1; wq(Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wq(Q);
        scl = 1'b1; wq(Q);
        scl = 1'b0; wq(Q);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; wq(Q);
        scl = 1'b1;   wq(Q / 2);
        b = sda_bus;  wq(Q / 2);
        scl = 1'b0;   wq(Q);
    endtask

    task automatic wr_byte(input logic [7:0] v, input string tag, input logic exp_ack);
        logic b;
        expect_item(tag, {7'b0, exp_ack});
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        get_bit(b);
        put_act({7'b0, ~b});
    endtask

    task automatic rd_byte(input string tag, input logic [7:0] exp_v, input logic mack);
        logic [7:0] v;
        logic b;
        expect_item(tag, exp_v);
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_act(v);
        send_bit(~mack);
    endtask

    task automatic write1(input logic [7:0] sel, input logic [7:0] a, input logic [7:0] d, input string tag);
        bus_start();
        wr_byte(sel, {tag, " select ack"}, 1'b1);
        wr_byte(a, {tag, " addr ack"}, 1'b1);
        wr_byte(d, {tag, " data ack"}, 1'b1);
        bus_stop();
        wq(PROG + 50);
    endtask

    task automatic rd_begin(input logic [7:0] sel, input logic [7:0] a);
        bus_start();
        wr_byte(sel, "R10 write select ack", 1'b1);
        wr_byte(a, "R10 word address ack", 1'b1);
        bus_start();
        wr_byte(sel | 8'h01, "R10 read select ack", 1'b1);
    endtask

    initial begin
        wq(5);
        rst_n = 1'b1;
        wq(2);
        // R1 reset state
        expect_item("R1 sda released after reset", 8'h00);
        put_act({7'b0, sda_oe});

        // R3 single byte write, R6 busy window
        bus_start();
        wr_byte(8'hA0, "R3 select ack", 1'b1);
        wr_byte(8'h10, "R3 addr ack", 1'b1);
        wr_byte(8'h5A, "R3 data ack", 1'b1);
        bus_stop();
        bus_start();
        wr_byte(8'hA0, "R6 select refused while programming", 1'b0);
        bus_stop();
        wq(PROG + 50);

        write1(8'hA0, 8'h00, 8'h11, "R4");
        write1(8'hA6, 8'hFF, 8'h77, "R2 block bits");

        // R4 / R10 random read
        rd_begin(8'hA0, 8'h10);
        rd_byte("R4 stored byte at 0x010", 8'h5A, 1'b0);
        bus_stop();

        // R8 wrap across the end of the array
        rd_begin(8'hA6, 8'hFF);
        rd_byte("R8 byte at 0x3FF", 8'h77, 1'b1);
        rd_byte("R8 wrap to 0x000", 8'h11, 1'b0);
        bus_stop();

        // R5 page write of 17 bytes from offset 4 of page 0x020
        bus_start();
        wr_byte(8'hA0, "R5 select ack", 1'b1);
        wr_byte(8'h24, "R5 addr ack", 1'b1);
        for (int i = 0; i < 17; i++) wr_byte(8'h40 + 8'(i), "R5 data ack", 1'b1);
        bus_stop();
        wq(PROG + 50);
        rd_begin(8'hA0, 8'h20);
        for (int o = 0; o < 16; o++) begin
            logic [7:0] ev;
            ev = 8'h40 + 8'((o + 12) % 16);
            if (o == 4) ev = 8'h50;
            rd_byte("R5 page content after wrap", ev, (o != 15));
        end
        bus_stop();

        // R2 mismatched select bytes
        bus_start();
        wr_byte(8'hB0, "R2 wrong device code", 1'b0);
        bus_stop();
        bus_start();
        wr_byte(8'hA8, "R2 unused block bit set", 1'b0);
        bus_stop();

        // R7 write protect
        wp = 1'b1;
        bus_start();
        wr_byte(8'hA0, "R7 select ack", 1'b1);
        wr_byte(8'h10, "R7 addr ack", 1'b1);
        wr_byte(8'h99, "R7 data acked under protect", 1'b1);
        bus_stop();
        bus_start();
        wr_byte(8'hA0, "R7 no programming window after protected stop", 1'b1);
        wr_byte(8'h10, "R7 addr ack", 1'b1);
        bus_start();
        wr_byte(8'hA1, "R7 read select ack", 1'b1);
        rd_byte("R7 array unchanged", 8'h5A, 1'b0);
        bus_stop();
        wp = 1'b0;

        wq(20);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule